// File: doc/BRIEF.md
# Three-ADC Raw Event Interleaver

The block assembles one uncompressed detector event from three analog-to-digital converters that run in parallel. Two converters (A and B) each read one side of a sensor, and a third converter (K) reads the other side. K has more channels than A or B. A trigger opens an event. The block first emits a header word that carries a running event number. After that, each pulse on the sample strobe latches one conversion slot: the current sample of every converter. The latched samples are then streamed out as 16-bit words on a valid/ready interface.

While all three converters still have channels, each slot yields three words in the order A, B, K. Once A and B are exhausted, the remaining K channels yield one word per slot. Every sample sits in its word moved up by three bit positions. With the default sizes (320, 320, 384), an event is 1025 words long. The final word is flagged with a last marker.

The event number starts at zero after reset. It advances by one for each accepted trigger and wraps at 16 bits. A trigger that arrives while an event is still open is refused and reported on an error pulse.

Top module: `raw_event_interleaver`

## Requirements
- R1: After reset, `evt_valid` and `evt_last` are low, `trig_err` is low, and the header of the first event carries event number 0.
- R2: The first word of each event is the event number. The number rises by one with every accepted trigger.
- R3: For slot index i below N_A, the slot produces three words in this order: converter A sample i, converter B sample i, converter K sample i.
- R4: For slot index i from N_A up to N_K-1, the slot produces only the converter K sample i.
- R5: Each sample word equals the 12-bit sample shifted left by 3. Bits 2..0 and bit 15 of the word are zero.
- R6: An event is exactly 1 + 2·N_A + N_K words long. `evt_last` is high with the final K word of the event and with no other word.
- R7: While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_data` and `evt_last` stay unchanged on the next cycle.
- R8: A trigger during an open event does not start a new event and does not change the event number. `trig_err` goes high for exactly the following cycle.
- R9: A strobe is taken only when an event is open, its header has been accepted, and no latched slot words remain unsent. A strobe at any other time is ignored.
- R10: A strobe while no event is open produces no output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Starts an event when no event is open |
| strobe | input | 1 | Marks a conversion slot; latches the three samples |
| adc_a | input | 12 | Converter A sample |
| adc_b | input | 12 | Converter B sample |
| adc_k | input | 12 | Converter K sample |
| evt_data | output | 16 | Output word |
| evt_valid | output | 1 | Output word present |
| evt_ready | input | 1 | Downstream accepts the word |
| evt_last | output | 1 | Final word of the event |
| trig_err | output | 1 | One-cycle pulse for a refused trigger |

## Verification
The bench builds the block with its default sizes: 320 channels for A and B, 384 for K, 12-bit samples and 16-bit words. This exercises the full 1025-word event and the 64-slot K-only tail. It also covers the slot 319 to slot 320 hand-over, where the order changes from three words per slot to one. The strobe rates and ready patterns vary between events, so strobes land while words are still held under backpressure. Triggers also arrive while events are still open, and a new event starts on the first cycle after the previous last word.

// File: rtl/raw_event_interleaver.sv
`timescale 1ns/1ps
module raw_event_interleaver #(
  parameter int N_A      = 320,
  parameter int N_K      = 384,
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int SHIFT    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic                strobe,
  input  logic [SAMPLE_W-1:0] adc_a,
  input  logic [SAMPLE_W-1:0] adc_b,
  input  logic [SAMPLE_W-1:0] adc_k,
  output logic [WORD_W-1:0]   evt_data,
  output logic                evt_valid,
  input  logic                evt_ready,
  output logic                evt_last,
  output logic                trig_err
);
  localparam int CH_W = $clog2(N_K);
  localparam logic [CH_W-1:0] MID_CH  = CH_W'(N_A);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_K - 1);

  logic                busy, hdr_v, buf_v;
  logic [1:0]          sel;
  logic [CH_W-1:0]     ch;
  logic [WORD_W-1:0]   evt_cnt, hdr_word;
  logic [SAMPLE_W-1:0] sa, sb, sk, cur;
  logic [WORD_W-1:0]   ext;
  logic                accept, cap;

  assign accept = trig & ~busy;
  assign cap    = busy & ~hdr_v & ~buf_v & strobe;

  always_comb begin
    case (sel)
      2'd0:    cur = sa;
      2'd1:    cur = sb;
      default: cur = sk;
    endcase
  end

  assign ext       = {{(WORD_W-SAMPLE_W){1'b0}}, cur};
  assign evt_data  = buf_v ? (ext << SHIFT) : hdr_word;
  assign evt_valid = hdr_v | buf_v;
  assign evt_last  = buf_v & (sel == 2'd2) & (ch == LAST_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hdr_v    <= 1'b0;
      buf_v    <= 1'b0;
      sel      <= 2'd0;
      ch       <= '0;
      evt_cnt  <= '0;
      hdr_word <= '0;
      sa       <= '0;
      sb       <= '0;
      sk       <= '0;
      trig_err <= 1'b0;
    end else begin
      trig_err <= trig & busy;
      if (accept) begin
        busy     <= 1'b1;
        hdr_v    <= 1'b1;
        hdr_word <= evt_cnt;
        evt_cnt  <= evt_cnt + 1'b1;
        ch       <= '0;
      end
      if (hdr_v && evt_ready) hdr_v <= 1'b0;
      if (cap) begin
        buf_v <= 1'b1;
        sa    <= adc_a;
        sb    <= adc_b;
        sk    <= adc_k;
        sel   <= (ch < MID_CH) ? 2'd0 : 2'd2;
      end
      if (buf_v && evt_ready) begin
        if (sel == 2'd2) begin
          buf_v <= 1'b0;
          if (ch == LAST_CH) busy <= 1'b0;
          else               ch   <= ch + 1'b1;
        end else begin
          sel <= sel + 2'd1;
        end
      end
    end
  end

  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_data) && $stable(evt_last));

  assert_last_on_k_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last |-> evt_valid && busy && sel == 2'd2);

  assert_header_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !busy |=> evt_valid && evt_data == $past(evt_cnt));

  assert_held_slot_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_v && !(evt_ready && sel == 2'd2) |=> $stable({sa, sb, sk}));

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !evt_valid);

  assert_err_needs_open_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_err |-> $past(busy));

  assert_tail_k_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_v && ch >= MID_CH |-> sel == 2'd2);
endmodule

// File: tb/raw_event_interleaver_bench.sv
`timescale 1ns/1ps
module raw_event_interleaver_bench;
  localparam int N_A = 320;
  localparam int N_K = 384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, strobe = 1'b0, evt_ready = 1'b0;
  logic [11:0] adc_a = '0, adc_b = '0, adc_k = '0;
  logic [15:0] evt_data;
  logic evt_valid, evt_last, trig_err;

  always #2.5 clk = ~clk;

  raw_event_interleaver u_raw_event_interleaver (
    .clk(clk), .rst_n(rst_n), .trig(trig), .strobe(strobe),
    .adc_a(adc_a), .adc_b(adc_b), .adc_k(adc_k),
    .evt_data(evt_data), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_last(evt_last), .trig_err(trig_err));

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  int unsigned q_data[$];
  bit          q_last[$];
  string       q_tag[$];
  bit m_busy = 1'b0, m_err = 1'b0, prev_ready = 1'b1;
  int m_ch = 0;
  int unsigned m_evt = 0;

  task automatic fail(input string req, input int unsigned act, input int unsigned exp);
    miscompares++;
    $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
  endtask

  task automatic push(input int unsigned d, input bit l, input string t);
    q_data.push_back(d); q_last.push_back(l); q_tag.push_back(t);
  endtask

  task automatic step(input bit t_in, input bit s_in, input bit r_in);
    bit ev, fire, cap, acc, lastw;
    @(negedge clk);
    vectors++;
    ev = (q_data.size() > 0);
    if (evt_valid !== ev)
      fail(m_busy ? (prev_ready ? "R9" : "R7") : "R10", evt_valid, ev);
    else if (ev) begin
      if (evt_data !== q_data[0][15:0]) fail(q_tag[0], evt_data, q_data[0]);
      if (evt_last !== q_last[0]) fail("R6", evt_last, q_last[0]);
      if (q_tag[0] != "R2" && (evt_data[2:0] != 3'd0 || evt_data[15]))
        fail("R5", evt_data, q_data[0]);
    end else if (evt_last !== 1'b0) fail("R6", evt_last, 0);
    if (trig_err !== m_err) fail("R8", trig_err, m_err);

    trig = t_in; strobe = s_in; evt_ready = r_in;
    adc_a = 12'($urandom); adc_b = 12'($urandom); adc_k = 12'($urandom);

    fire = ev && r_in;
    cap  = m_busy && !ev && s_in;
    acc  = t_in && !m_busy;
    m_err = t_in && m_busy;
    if (fire) begin
      lastw = q_last[0];
      void'(q_data.pop_front()); void'(q_last.pop_front()); void'(q_tag.pop_front());
      if (lastw) m_busy = 1'b0;
    end
    if (cap) begin
      if (m_ch < N_A) begin
        push(int'(adc_a) << 3, 1'b0, "R3");
        push(int'(adc_b) << 3, 1'b0, "R3");
        push(int'(adc_k) << 3, 1'b0, "R3");
      end else
        push(int'(adc_k) << 3, m_ch == N_K - 1, (m_ch == N_K - 1) ? "R6" : "R4");
      m_ch++;
    end
    if (acc) begin
      push(m_evt, 1'b0, "R2");
      m_evt = (m_evt + 1) & 32'hFFFF;
      m_busy = 1'b1;
      m_ch = 0;
    end
    prev_ready = r_in;
  endtask

  task automatic run_event(input int ready_pct, input int strobe_pct, input int trig_pct);
    int guard = 0;
    int words = 0;
    step(1'b1, 1'b0, 1'b1);
    while ((m_busy || q_data.size() > 0) && guard < 40000) begin
      if (q_data.size() > 0 && prev_ready) words++;
      step(m_busy && ($urandom % 100 < trig_pct), $urandom % 100 < strobe_pct,
           $urandom % 100 < ready_pct);
      guard++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (evt_valid !== 1'b0 || evt_last !== 1'b0 || trig_err !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: actual %b%b%b expected 000", evt_valid, evt_last, trig_err);
    end
    rst_n = 1'b1;
    // R10: strobes with no open event
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1);
    // R1/R2/R3/R4/R6: first event (number 0), free-flowing output
    run_event(100, 40, 0);
    // R7/R8/R9: random backpressure, dense strobes, triggers during the event
    run_event(70, 90, 2);
    // R7/R9: heavy stalls
    run_event(25, 100, 1);
    // back-to-back event right after the last word
    run_event(100, 100, 0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule